// File: doc/BRIEF.md
# Multi-hart timer and software-interrupt controller

This block serves the timer and inter-processor interrupts of a small group of harts. A single 64-bit time base is shared by all harts. Each hart has its own 64-bit deadline register and one software-interrupt flag. The two per-hart output vectors, `timer_irq` and `soft_irq`, connect straight to the interrupt inputs of the harts.

Software uses the block through a plain 32-bit register port that covers a 64 KiB window. The 64-bit registers are accessed as two 32-bit words. A hart programs its deadline, and its timer interrupt stays raised for as long as the deadline lies strictly in the past. Any hart can post a software interrupt to any other hart by writing 1 into that hart's flag word, and it clears the flag by writing any other value.

The time base does not count every clock. It moves forward by a fixed step once per prescale period. Both the step and the period are parameters.

Top module: `mhart_tick_irq`

## Requirements
- R1: After reset the time value is 0, every software flag is 0 and every deadline is 0, so both `timer_irq` and `soft_irq` are all zero.
- R2: Hart h's software flag sits at offset 0x0000 + 4*h. A write of exactly 0x00000001 sets the flag and a write of any other value clears it. The flags of the other harts do not change. A read returns the flag in bit 0 and zero in all other bits.
- R3: Hart h's deadline sits at offset 0x4000 + 8*h, with bits 31:0 at +0 and bits 63:32 at +4. Both words can be read and written. A write to one word leaves the other word unchanged.
- R4: The time value is read at offset 0xBFF8 (bits 31:0) and at 0xBFFC (bits 63:32). Writes to these two offsets have no effect.
- R5: The time value starts at 0 and rises by STEP (default 10) once every PRESCALE (default 10) clock cycles. After k rising edges out of reset, it equals floor(k/PRESCALE)*STEP.
- R6: `timer_irq[h]` is 1 exactly when hart h's deadline is strictly less than the time value, compared as 64-bit unsigned numbers. The output follows the register contents within the same cycle, so it can drop again when the deadline is raised.
- R7: A read of an unmapped offset returns 0, and a write to one changes nothing. Unmapped offsets include the flag and deadline slots of harts numbered NUM_HARTS and above.
- R8: `bus_rdata` holds the read result in the cycle after `bus_re` and is 0 in any cycle that follows a cycle without `bus_re`. Address bits 1:0 are ignored. A read and a write to the same word in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Byte offset within the 64 KiB window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_re |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
The bench targets the equality point of the timer compare: at the moment time equals the deadline the interrupt must still be low. A design that used less-or-equal would raise it one tick early. It also sets the top bit of a deadline, which a signed compare would read as a past value and fire on. A high-word write followed by a low-word write is read back word by word to catch a half-write that clobbers its partner, and raising the deadline above the current time must drop the interrupt again. Writes of values other than 1 to the software flags, writes to hart slots past the last hart, and writes to the time words are each followed by reads that would expose a flag set on any nonzero value, an aliased slot or a writable time base.

// File: rtl/mhti_pkg.sv
package mhti_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_SW   = 2'd1,
    REG_CMP  = 2'd2,
    REG_TIME = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [11:0] idx;
    logic        hi;
  } reg_hit_t;

  // Map a byte offset to a register class, hart index and word half.
  function automatic reg_hit_t decode_off(input logic [15:0] a, input int unsigned nh);
    reg_hit_t    r;
    logic [11:0] cidx;
    r    = '0;
    cidx = 12'((a - 16'h4000) >> 3);
    if (a[15:14] == 2'b00) begin
      if ({20'd0, a[13:2]} < nh) begin
        r.kind = REG_SW;
        r.idx  = a[13:2];
      end
    end else if (a[15:3] == 13'h17FF) begin
      r.kind = REG_TIME;
      r.hi   = a[2];
    end else if (a < 16'hBFF8) begin
      if ({20'd0, cidx} < nh) begin
        r.kind = REG_CMP;
        r.idx  = cidx;
        r.hi   = a[2];
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] time_advance(input logic [63:0] t, input int unsigned step);
    return t + 64'(step);
  endfunction

  function automatic logic timer_due(input logic [63:0] deadline, input logic [63:0] now);
    return deadline < now;
  endfunction

  function automatic logic sw_value_sets(input logic [31:0] v);
    return v == 32'd1;
  endfunction

endpackage

// File: rtl/mhti_timebase.sv
module mhti_timebase
  import mhti_pkg::*;
#(
  parameter int unsigned PRESCALE = 10,
  parameter int unsigned STEP     = 10
) (
  input  logic        clk,
  input  logic        rst,
  output logic [63:0] time_q,
  output logic        tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pcnt;

  assign tick = (pcnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt   <= '0;
      time_q <= '0;
    end else if (tick) begin
      pcnt   <= '0;
      time_q <= time_advance(time_q, STEP);
    end else begin
      pcnt   <= pcnt + 1'b1;
    end
  end

  // R5: time only moves on a prescaled tick
  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(time_q));

  // R5: every tick moves time forward
  a_r5_tick_advances: assert property (@(posedge clk) disable iff (rst)
    tick |=> (time_q > $past(time_q)));

endmodule

// File: rtl/mhti_hart_slot.sv
module mhti_hart_slot
  import mhti_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_we,
  input  logic        cmp_we,
  input  logic        hi_sel,
  input  logic [31:0] wdata,
  input  logic [63:0] time_now,
  output logic        sw_bit,
  output logic [63:0] cmp_q,
  output logic        irq_timer
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_bit <= 1'b0;
      cmp_q  <= '0;
    end else begin
      if (sw_we) sw_bit <= sw_value_sets(wdata);
      if (cmp_we) begin
        if (hi_sel) cmp_q[63:32] <= wdata;
        else        cmp_q[31:0]  <= wdata;
      end
    end
  end

  assign irq_timer = timer_due(cmp_q, time_now);

  // R2: a flag changes only on a write addressed to this hart
  a_r2_flag_untouched: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> $stable(sw_bit));

  // R3: a low-word write keeps the high word
  a_r3_keep_high: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && !hi_sel) |=> (cmp_q[63:32] == $past(cmp_q[63:32])));

  // R3: a high-word write keeps the low word
  a_r3_keep_low: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && hi_sel) |=> (cmp_q[31:0] == $past(cmp_q[31:0])));

  // R6: with time rising, a raised timer interrupt drops only after a deadline write
  a_r6_sticky_until_write: assert property (@(posedge clk) disable iff (rst)
    (irq_timer && !cmp_we) |=> irq_timer);

endmodule

// File: rtl/mhart_tick_irq.sv
module mhart_tick_irq
  import mhti_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned PRESCALE  = 10,
  parameter int unsigned STEP      = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_re,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] timer_irq,
  output logic [NUM_HARTS-1:0] soft_irq
);

  reg_hit_t            hit;
  logic [63:0]         time_now;
  logic                tick;
  logic [NUM_HARTS-1:0] sw_we;
  logic [NUM_HARTS-1:0] cmp_we;
  logic [63:0]         cmp_all [NUM_HARTS];
  logic [31:0]         rd_mux;

  assign hit = decode_off(bus_addr, NUM_HARTS);

  mhti_timebase #(.PRESCALE(PRESCALE), .STEP(STEP)) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .time_q (time_now),
    .tick   (tick)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign sw_we[h]  = bus_we && (hit.kind == REG_SW)  && (hit.idx == 12'(h));
    assign cmp_we[h] = bus_we && (hit.kind == REG_CMP) && (hit.idx == 12'(h));

    mhti_hart_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .sw_we     (sw_we[h]),
      .cmp_we    (cmp_we[h]),
      .hi_sel    (hit.hi),
      .wdata     (bus_wdata),
      .time_now  (time_now),
      .sw_bit    (soft_irq[h]),
      .cmp_q     (cmp_all[h]),
      .irq_timer (timer_irq[h])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (hit.kind)
      REG_SW: begin
        for (int h = 0; h < NUM_HARTS; h++)
          if (hit.idx == 12'(h)) rd_mux = {31'd0, soft_irq[h]};
      end
      REG_CMP: begin
        for (int h = 0; h < NUM_HARTS; h++)
          if (hit.idx == 12'(h)) rd_mux = hit.hi ? cmp_all[h][63:32] : cmp_all[h][31:0];
      end
      REG_TIME: rd_mux = hit.hi ? time_now[63:32] : time_now[31:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_re ? rd_mux : 32'd0;
  end

  // R8: no read in the previous cycle means zero read data
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == 32'd0));

  // R7: unmapped reads return zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && hit.kind == REG_NONE) |=> (bus_rdata == 32'd0));

  // R2: at most one hart's flag is written per cycle
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw_we));

  // R4: an access to the time words never writes a flag or a deadline
  a_r4_time_readonly: assert property (@(posedge clk) disable iff (rst)
    (hit.kind == REG_TIME) |-> (sw_we == '0 && cmp_we == '0));

endmodule

// File: tb/mhart_tick_irq_tb_top.sv
module mhart_tick_irq_tb_top;
  localparam int unsigned NH = 4;
  localparam int unsigned PS = 10;
  localparam int unsigned ST = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [NH-1:0] timer_irq, soft_irq;

  int checks = 0;
  int errors = 0;
  longint unsigned cyc = 0;
  int wd = 0;

  mhart_tick_irq #(.NUM_HARTS(NH), .PRESCALE(PS), .STEP(ST)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .timer_irq(timer_irq), .soft_irq(soft_irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
    wd <= wd + 1;
    if (wd > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog R5 actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {hart[3:0], value[31:0], expected flags[3:0]}
  localparam logic [39:0] SWV [8] = '{
    {4'd0, 32'h0000_0001, 4'b0001},
    {4'd2, 32'h0000_0001, 4'b0101},
    {4'd1, 32'h0000_0005, 4'b0101},
    {4'd3, 32'h0000_0001, 4'b1101},
    {4'd0, 32'h0000_0000, 4'b1100},
    {4'd2, 32'h0000_0002, 4'b1000},
    {4'd1, 32'h0000_0001, 4'b1010},
    {4'd3, 32'h8000_0001, 4'b0010}
  };

  function automatic longint unsigned model_time(input longint unsigned k);
    return (k / PS) * ST;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output longint unsigned t_exp);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    t_exp = model_time(cyc);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] d;
    longint unsigned te;
    longint unsigned target;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 timer_irq after reset", 64'(timer_irq), 64'd0);
    check("R1 soft_irq after reset", 64'(soft_irq), 64'd0);
    rd(16'hBFF8, d, te);
    check("R1 time low after reset", 64'(d), 64'(te));
    check("R1 time starts at zero", 64'(te), 64'd0);
    rd(16'h4008, d, te);
    check("R1 deadline after reset", 64'(d), 64'd0);

    // R8 idle cycle gives zero
    @(negedge clk);
    check("R8 rdata zero when idle", 64'(bus_rdata), 64'd0);

    // R6/R5 first increment raises all timer interrupts (deadline 0 < time)
    while (cyc < PS - 1) @(negedge clk);
    check("R6 equal time keeps timer low", 64'(timer_irq), 64'd0);
    @(negedge clk);
    check("R5 first step at PRESCALE edges", 64'(timer_irq), 64'hF);

    // R2 vector table
    for (int i = 0; i < 8; i++) begin
      wr(16'(SWV[i][39:36] * 4), SWV[i][35:4]);
      check($sformatf("R2 flags vector %0d", i), 64'(soft_irq), 64'(SWV[i][3:0]));
      rd(16'(SWV[i][39:36] * 4), d, te);
      check($sformatf("R2 flag readback %0d", i), 64'(d), 64'(SWV[i][3:0] >> SWV[i][39:36]) & 64'd1);
    end

    // R3 high then low on hart1
    wr(16'h400C, 32'h0000_0001);
    check("R6 raised deadline drops hart1 irq", 64'(timer_irq[1]), 64'd0);
    wr(16'h4008, 32'h0000_0005);
    rd(16'h4008, d, te);
    check("R3 hart1 low word", 64'(d), 64'h5);
    rd(16'h400C, d, te);
    check("R3 hart1 high kept", 64'(d), 64'h1);
    wr(16'h4008, 32'h1234_5678);
    rd(16'h400C, d, te);
    check("R3 high survives low write", 64'(d), 64'h1);
    rd(16'h4009, d, te);
    check("R8 low address bits ignored", 64'(d), 64'h1234_5678);

    // R6 unsigned compare on hart3
    wr(16'h401C, 32'h8000_0000);
    check("R6 top-bit deadline is future", 64'(timer_irq[3]), 64'd0);
    check("R6 hart0 irq still high", 64'(timer_irq[0]), 64'd1);

    // R6 strict compare at equality on hart2
    @(negedge clk);
    target = model_time(cyc) + 3 * ST;
    wr(16'h4010, 32'(target));
    check("R6 future deadline low", 64'(timer_irq[2]), 64'd0);
    while (model_time(cyc) < target) @(negedge clk);
    check("R6 deadline equal to time is low", 64'(timer_irq[2]), 64'd0);
    while (model_time(cyc) < target + ST) @(negedge clk);
    check("R6 fires after deadline passed", 64'(timer_irq[2]), 64'd1);

    // R4 time read-only and readable
    wr(16'hBFF8, 32'hFFFF_FFFF);
    wr(16'hBFFC, 32'hFFFF_FFFF);
    rd(16'hBFF8, d, te);
    check("R4 time low unaffected by writes", 64'(d), 64'(te));
    rd(16'hBFFC, d, te);
    check("R4 time high", 64'(d), te >> 32);

    // R7 unmapped
    wr(16'h8000, 32'h0000_0001);
    rd(16'h8000, d, te);
    check("R7 unmapped read zero", 64'(d), 64'd0);
    wr(16'h0010, 32'h0000_0001);
    check("R7 hart slot past last leaves flags", 64'(soft_irq), 64'b0010);
    rd(16'h0010, d, te);
    check("R7 hart slot past last reads zero", 64'(d), 64'd0);
    wr(16'h4020, 32'hAAAA_AAAA);
    rd(16'h4020, d, te);
    check("R7 deadline past last reads zero", 64'(d), 64'd0);
    rd(16'h4000, d, te);
    check("R7 hart0 deadline untouched", 64'(d), 64'd0);

    // R5 time after a long run
    repeat (37) @(negedge clk);
    rd(16'hBFF8, d, te);
    check("R5 time tracks edge count", 64'(d), 64'(te));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule